// File: doc/BRIEF.md
# JTAG Register-Access Scan Chain

This block is a JTAG data-register chain that lets an external debugger read and write a bank of up to 128 internal 32-bit registers through ordinary DR scans. The TAP controller, the instruction register and the chain-number register live outside the block. The block receives their Capture-DR, Shift-DR and Update-DR strobes, the TDI bit, a flag that is high while INTEST is the current instruction, and the currently selected chain number. It drives TDO. Everything runs on TCK, and an active-low asynchronous TAP reset clears it.

Each access takes one full 40-bit DR scan. The bit nearest TDI (the LSB) is the first bit shifted in and out. Bits [31:0] carry data, bits [38:32] carry a register address, and bit 39 is the access kind: 1 means write and 0 means read. A write takes effect at Update-DR. A read is split across two scans. The first scan posts the address. The register value is latched shortly after its Update-DR, and the data field of the next scan's Capture-DR returns that value.

The internal bus (address, write data, write strobe, read strobe) is exposed as outputs. The block also contains the register bank that the bus serves.

Top module: `jtag_reg_chain`

## Requirements
- R1: While reset is held and right after it, `tdo_o` is 0 and both bus strobes are low. Every register holds zero, and the first capture returns zero data.
- R2: When selected with Shift-DR high, each TCK rising edge moves TDI into bit 39 and shifts the chain one place toward bit 0. `tdo_o` shows bit 0, so a bit entered on TDI reaches TDO after exactly 40 shifts.
- R3: At a selected Capture-DR, bits [39:32] load zero and bits [31:0] load the most recent read result.
- R4: A selected Update-DR with bit 39 = 1 raises `bus_we_o` for exactly the next TCK cycle. During that cycle `bus_addr_o` equals the shifted bits [38:32] and `bus_wdata_o` equals the shifted bits [31:0], and the addressed register takes that data.
- R5: A selected Update-DR with bit 39 = 0 raises `bus_re_o` for exactly the next TCK cycle, with `bus_addr_o` equal to the shifted address. The scan that posts a read returns the previous result, and the following scan's capture returns the addressed register's value.
- R6: If `chain_num_i` is not 6 or `intest_i` is low, `tdo_o` is 0 and no bus strobe is raised. Scans made in that state change no register and no read result.
- R7: An asynchronous reset pulse discards a posted read result. The next capture returns zero, and the register bank returns to zero.
- R8: All 128 addresses store values independently. A read of any address returns the last value written to it.
- R9: A write between a read scan and the next capture does not disturb the read result already latched. That capture returns the value as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous TAP reset, active low |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| tdi_i | input | 1 | Serial test data in |
| intest_i | input | 1 | INTEST is the current instruction |
| chain_num_i | input | 5 | Selected scan-chain number |
| tdo_o | output | 1 | Serial test data out (chain bit 0) |
| bus_addr_o | output | 7 | Register address of the current access |
| bus_wdata_o | output | 32 | Write data |
| bus_we_o | output | 1 | Single-cycle write strobe |
| bus_re_o | output | 1 | Single-cycle read strobe |

## Verification
`tdo_o` follows chain bit 0 with no delay, so the bench reads each scan bit on the falling edge before the shift edge. The first bit it reads is therefore the value loaded by the capture edge. Bus strobes are registered from the Update-DR edge and are checked on the next falling edge, one cycle later; a second sample one further cycle on confirms they have dropped. The read value is latched one edge after the strobe. The bench gives the capture of the next scan at least three TCK edges of margin after Update-DR, and it compares that capture against a model in which each read moves the register value into a latched result.

// File: rtl/jtag_chain_pkg.sv
package jtag_chain_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned CHAIN_W  = 5;
  localparam int unsigned CHAIN_ID = 6;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/jtag_shift_reg.sv
module jtag_shift_reg
  import jtag_chain_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          capture_i,
  input  logic          shift_i,
  input  logic          tdi_i,
  input  logic [DW-1:0] cap_data_i,
  output logic [DW-1:0] frm_data_o,
  output logic [AW-1:0] frm_addr_o,
  output acc_kind_e     frm_kind_o,
  output logic          tdo_o
);
  localparam int unsigned SR_W = DW + AW + 1;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i) begin
      if (capture_i) begin
        sr_q <= {{(AW+1){1'b0}}, cap_data_i};
      end else if (shift_i) begin
        sr_q <= {tdi_i, sr_q[SR_W-1:1]};
      end
    end
  end

  assign frm_data_o = sr_q[DW-1:0];
  assign frm_addr_o = sr_q[DW+AW-1:DW];
  assign frm_kind_o = acc_kind_e'(sr_q[SR_W-1]);
  assign tdo_o      = sel_i & sr_q[0];
endmodule

// File: rtl/jtag_access_ctrl.sv
module jtag_access_ctrl
  import jtag_chain_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          update_i,
  input  logic [DW-1:0] frm_data_i,
  input  logic [AW-1:0] frm_addr_i,
  input  acc_kind_e     frm_kind_i,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      re_o <= 1'b0;
      if (sel_i && update_i) begin
        addr_o <= frm_addr_i;
        if (frm_kind_i == ACC_WRITE) begin
          we_o    <= 1'b1;
          wdata_o <= frm_data_i;
        end else begin
          re_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/jtag_reg_bank.sv
module jtag_reg_bank
  import jtag_chain_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned NUM_REGS = 128
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [AW:0] NUM_L = (AW+1)'(NUM_REGS);

  logic [DW-1:0] mem_q [NUM_REGS];
  logic          in_range;

  assign in_range = {1'b0, addr_i} < NUM_L;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))     mem_q[g] <= wdata_i;
    end
  end

  // latched read result, held until the next read strobe
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       rd_data_o <= '0;
    else if (re_i)     rd_data_o <= in_range ? mem_q[addr_i[IDX_W-1:0]] : '0;
  end
endmodule

// File: rtl/jtag_reg_chain.sv
module jtag_reg_chain
  import jtag_chain_pkg::*;
#(
  parameter int unsigned DW       = DATA_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned CW       = CHAIN_W,
  parameter int unsigned CHAIN_NO = CHAIN_ID,
  parameter int unsigned NUM_REGS = 128
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          capture_dr_i,
  input  logic          shift_dr_i,
  input  logic          update_dr_i,
  input  logic          tdi_i,
  input  logic          intest_i,
  input  logic [CW-1:0] chain_num_i,
  output logic          tdo_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o
);
  logic          sel;
  logic [DW-1:0] frm_data, rd_data;
  logic [AW-1:0] frm_addr;
  acc_kind_e     frm_kind;

  assign sel = intest_i && (chain_num_i == CW'(CHAIN_NO));

  jtag_shift_reg #(.DW(DW), .AW(AW)) i_sr (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .capture_i  (capture_dr_i),
    .shift_i    (shift_dr_i),
    .tdi_i      (tdi_i),
    .cap_data_i (rd_data),
    .frm_data_o (frm_data),
    .frm_addr_o (frm_addr),
    .frm_kind_o (frm_kind),
    .tdo_o      (tdo_o)
  );

  jtag_access_ctrl #(.DW(DW), .AW(AW)) i_ctrl (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .update_i   (update_dr_i),
    .frm_data_i (frm_data),
    .frm_addr_i (frm_addr),
    .frm_kind_i (frm_kind),
    .we_o       (bus_we_o),
    .re_o       (bus_re_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o)
  );

  jtag_reg_bank #(.DW(DW), .AW(AW), .NUM_REGS(NUM_REGS)) i_bank (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_o),
    .re_i      (bus_re_o),
    .addr_i    (bus_addr_o),
    .wdata_i   (bus_wdata_o),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/jtag_reg_chain_chk.sv
module jtag_reg_chain_chk #(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 7,
  parameter int unsigned CW       = 5,
  parameter int unsigned CHAIN_NO = 6
) (
  input logic          tck_i,
  input logic          rst_ni,
  input logic          update_dr_i,
  input logic          intest_i,
  input logic [CW-1:0] chain_num_i,
  input logic          tdo_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_we_o,
  input logic          bus_re_o
);
  logic sel_c;
  assign sel_c = intest_i && (chain_num_i == CW'(CHAIN_NO));

  p_we_single_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);
  p_we_cause_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_we_o |-> $past(update_dr_i && sel_c));
  p_re_single_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_re_o |=> !bus_re_o);
  p_re_cause_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bus_re_o |-> $past(update_dr_i && sel_c));
  p_one_kind_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));
  p_tdo_quiet_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_c |-> !tdo_o);
  p_no_access_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_dr_i && !sel_c) |=> !(bus_we_o || bus_re_o));
  p_bus_hold_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$past(update_dr_i && sel_c) |-> ($stable(bus_addr_o) && $stable(bus_wdata_o)));
endmodule

bind jtag_reg_chain jtag_reg_chain_chk #(
  .DW(DW), .AW(AW), .CW(CW), .CHAIN_NO(CHAIN_NO)
) i_chk (
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .update_dr_i (update_dr_i),
  .intest_i    (intest_i),
  .chain_num_i (chain_num_i),
  .tdo_o       (tdo_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o)
);

// File: tb/test_jtag_reg_chain.sv
module test_jtag_reg_chain;
  logic        tck_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        capture_dr_i = 1'b0, shift_dr_i = 1'b0, update_dr_i = 1'b0;
  logic        tdi_i = 1'b0, intest_i = 1'b1;
  logic [4:0]  chain_num_i = 5'd6;
  logic        tdo_o;
  logic [6:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic        bus_we_o, bus_re_o;

  int checks = 0, errors = 0;
  logic [31:0] ref_mem [128];
  logic [31:0] ref_rd;

  always #4 tck_i = ~tck_i;

  jtag_reg_chain i_jtag_reg_chain (.*);

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] frame(input bit wr, input logic [6:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  task automatic do_scan(input logic [79:0] fin, input int nbits, output logic [79:0] fout,
                         output logic we_s, output logic re_s, output logic [6:0] a_s,
                         output logic [31:0] d_s, output logic late);
    fout = '0;
    @(negedge tck_i) capture_dr_i = 1'b1;
    @(negedge tck_i) capture_dr_i = 1'b0; shift_dr_i = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) @(negedge tck_i);
      tdi_i = fin[i];
      fout[i] = tdo_o;
    end
    @(negedge tck_i) shift_dr_i = 1'b0; update_dr_i = 1'b1;
    @(negedge tck_i) update_dr_i = 1'b0;
    we_s = bus_we_o; re_s = bus_re_o; a_s = bus_addr_o; d_s = bus_wdata_o;
    @(negedge tck_i) late = bus_we_o | bus_re_o;
    @(negedge tck_i);
  endtask

  task automatic access(input bit wr, input logic [6:0] a, input logic [31:0] d, input string req);
    logic [79:0] fo;
    logic we_s, re_s, late;
    logic [6:0] a_s;
    logic [31:0] d_s;
    do_scan({40'b0, frame(wr, a, d)}, 40, fo, we_s, re_s, a_s, d_s, late);
    chk(fo[31:0] == ref_rd, {req, "/R3 capture data"}, fo[31:0], ref_rd);
    chk(fo[39:32] == 8'h0, "R3 capture upper zero", fo[39:32], 0);
    if (wr) begin
      chk(we_s && !re_s && a_s == a && d_s == d, "R4 write strobe", {we_s, re_s, a_s, d_s}, {2'b10, a, d});
      chk(!late, "R4 single cycle", late, 0);
      ref_mem[a] = d;
    end else begin
      chk(re_s && !we_s && a_s == a, "R5 read strobe", {we_s, re_s, a_s}, {2'b01, a});
      chk(!late, "R5 single cycle", late, 0);
      ref_rd = ref_mem[a];
    end
  endtask

  task automatic unsel_scan(input string req);
    logic [79:0] fo;
    logic we_s, re_s, late;
    logic [6:0] a_s;
    logic [31:0] d_s;
    do_scan({40'b0, frame(1'b1, 7'd5, 32'hDEAD_BEEF)}, 40, fo, we_s, re_s, a_s, d_s, late);
    chk(fo == '0, {req, " tdo quiet"}, fo, 0);
    chk(!we_s && !re_s && !late, {req, " no access"}, {we_s, re_s, late}, 0);
  endtask

  task automatic clear_ref();
    for (int k = 0; k < 128; k++) ref_mem[k] = '0;
    ref_rd = '0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge tck_i);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [79:0] fi, fo;
    logic we_s, re_s, late;
    logic [6:0] a_s;
    logic [31:0] d_s;
    void'($urandom(32'h5EED_0042));
    clear_ref();
    #1;
    chk(tdo_o == 0 && !bus_we_o && !bus_re_o, "R1 in reset", {tdo_o, bus_we_o, bus_re_o}, 0);
    repeat (3) @(negedge tck_i);
    rst_ni = 1'b1;
    @(negedge tck_i);
    chk(tdo_o == 0 && !bus_we_o && !bus_re_o, "R1 after reset", {tdo_o, bus_we_o, bus_re_o}, 0);

    // first capture after reset returns zero; register 9 is zero
    access(1'b0, 7'd9, 32'h0, "R1");
    access(1'b0, 7'd9, 32'h0, "R1");

    // R2: 80-bit shift, bits come out after 40 positions
    fi[39:0]  = {$urandom(), $urandom()};
    fi[79:40] = frame(1'b0, 7'd0, 32'h0);
    do_scan(fi, 80, fo, we_s, re_s, a_s, d_s, late);
    chk(fo[79:40] == fi[39:0], "R2 delay 40", fo[79:40], fi[39:0]);
    chk(fo[31:0] == ref_rd, "R2/R3 capture", fo[31:0], ref_rd);
    chk(re_s && a_s == 7'd0, "R2 trailing frame read", {re_s, a_s}, {1'b1, 7'd0});
    ref_rd = ref_mem[0];

    // corner addresses
    access(1'b1, 7'd0,   32'hA5A5_0001, "R8");
    access(1'b1, 7'd127, 32'hFFFF_FFFF, "R8");
    access(1'b0, 7'd127, 32'h0, "R8");
    access(1'b0, 7'd0,   32'h0, "R8");
    access(1'b0, 7'd0,   32'h0, "R8");

    // R9: read latched, then write same address, then capture
    access(1'b1, 7'd20, 32'h1111_2222, "R9");
    access(1'b0, 7'd20, 32'h0, "R9");
    access(1'b1, 7'd20, 32'h3333_4444, "R9");
    access(1'b0, 7'd20, 32'h0, "R9");
    access(1'b0, 7'd5,  32'h0, "R9");

    // R6: deselected scans
    chain_num_i = 5'd3;
    unsel_scan("R6 wrong chain");
    chain_num_i = 5'd6; intest_i = 1'b0;
    unsel_scan("R6 no intest");
    intest_i = 1'b1;
    access(1'b0, 7'd5, 32'h0, "R6");
    access(1'b0, 7'd5, 32'h0, "R6");

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [6:0] ra;
      ra = 7'($urandom_range(0, 127));
      if (n % 3 == 0) ra = 7'($urandom_range(0, 3));
      access(1'($urandom()), ra, $urandom(), "R8");
    end

    // R7: reset drops posted read
    access(1'b1, 7'd33, 32'hCAFE_F00D, "R7");
    access(1'b0, 7'd33, 32'h0, "R7");
    @(negedge tck_i) rst_ni = 1'b0;
    #1 chk(tdo_o == 0 && !bus_we_o && !bus_re_o, "R7 in reset", {tdo_o, bus_we_o, bus_re_o}, 0);
    repeat (2) @(negedge tck_i);
    rst_ni = 1'b1;
    clear_ref();
    access(1'b0, 7'd33, 32'h0, "R7");
    access(1'b0, 7'd33, 32'h0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule